// File: doc/BRIEF.md
# COBS Signal Packet Receiver

This block sits on the read side of a controller's signal channel. It takes the channel's byte stream, cuts it into packets at every zero byte, undoes the Consistent Overhead Byte Stuffing of each packet, and classifies the packet by its leading 32-bit one-hot flag. Packets that carry a configuration acknowledgement, a device-table header or a device instance are turned into single-cycle pulses on typed outputs. Null packets and packets of no interest vanish. Malformed packets raise an error pulse and are dropped.

Because a reader may join the stream at any point, decoding restarts at every zero byte. A bad or partial packet never affects the next one. After a device-table header, the block counts the valid device-instance packets that follow. It pulses a done flag when the announced number has arrived. Descriptor contents are passed through word by word and are not interpreted.

The byte input is a valid/ready stream. `in_ready` is low only while `rst` is high, so the block never applies back-pressure during operation. A byte transfers on every rising edge where `in_valid` and `in_ready` are both high, and `in_data` is ignored when `in_valid` is low. The outputs are plain strobes with no ready: a consumer that cannot take one result per cycle must buffer it itself.

Top module: `cobs_sig_rx`

## Requirements
- R1: A transferred zero byte ends the current packet, and the next non-zero byte starts decoding afresh. A zero with no bytes since the previous zero is an empty packet and produces no output.
- R2: Inside a packet, a code byte c is followed by c-1 literal bytes. When c is below 0xFF and another code byte follows, one zero byte is implied between the two groups. The group that ends at the delimiter adds no zero.
- R3: The first four decoded bytes form the flag, least-significant byte first. A flag other than 0x1, 0x2, 0x4, 0x8, 0x10, 0x20 or 0x40 makes the packet malformed.
- R4: A packet with flag 0x1 (null) produces no output of any kind, whatever its payload.
- R5: Flags 0x2, 0x4 and 0x10 with an empty payload pulse `ack_wr_ok`, `ack_wr_fail` and `ack_rd_fail` respectively. Any payload makes the packet malformed.
- R6: Flag 0x8 with exactly four payload bytes pulses `ack_rd_ok`, with `rd_value` holding those bytes least-significant first. Any other length makes the packet malformed.
- R7: Flag 0x20 with exactly four payload bytes pulses `tab_valid`, with `tab_count` holding the device count least-significant byte first. Any other length makes the packet malformed.
- R8: Flag 0x40 with a payload of 4+4k bytes (k ≥ 0) pulses `dev_valid`, with `dev_addr` set from the first four payload bytes and `dev_words` = k. Each descriptor word j is pulsed on `desc_valid` with `desc_word` and `desc_index` = j as soon as its fourth byte is decoded. Any other payload length makes the packet malformed.
- R9: A packet is malformed, and pulses `pkt_err` instead of any other result, when its last code byte runs past the delimiter, when it has fewer than four decoded bytes, or when R3, R5, R6, R7 or R8 rejects it.
- R10: After a `tab_valid` with count N > 0, `tab_done` pulses together with the N-th following `dev_valid`. With N = 0 it pulses together with `tab_valid` itself. A new header restarts the count. Device packets outside an open table do not pulse it.
- R11: The per-packet result (ack, `tab_valid`, `dev_valid`, `pkt_err`, `tab_done`) appears in the cycle after the delimiter transfers. A `desc_valid` appears in the cycle after the byte that completes the word. `in_ready` is high whenever `rst` is low.
- R12: While `rst` (synchronous, active high) is high and in the cycle after it falls, every output strobe is low and `in_ready` is low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| ack_wr_ok | output | 1 | Write acknowledged pulse |
| ack_wr_fail | output | 1 | Write refused pulse |
| ack_rd_ok | output | 1 | Read acknowledged pulse |
| ack_rd_fail | output | 1 | Read refused pulse |
| rd_value | output | 32 | Read result, valid with ack_rd_ok |
| tab_valid | output | 1 | Device-table header pulse |
| tab_count | output | 32 | Announced device count, valid with tab_valid |
| desc_valid | output | 1 | Descriptor word pulse |
| desc_word | output | 32 | Descriptor word |
| desc_index | output | CNT_W-2 | Word position within the descriptor |
| dev_valid | output | 1 | Device instance complete pulse |
| dev_addr | output | 32 | Device address, valid with dev_valid |
| dev_words | output | CNT_W-2 | Descriptor word count, valid with dev_valid |
| tab_done | output | 1 | Announced device count reached |
| pkt_err | output | 1 | Malformed packet dropped |

## Verification
Every result of this block is due exactly one clock after the byte that causes it transfers. For packet results that byte is the delimiter; for descriptor words it is the byte that completes the word, which may be a code byte carrying an implied zero. The bench's model decodes the bytes received so far after each transfer and sets the expectation for the next cycle only. Every output is then compared on the falling edge of that cycle. An output that is strobed early, late or twice therefore shows up as a mismatch on a named cycle. Idle cycles with `in_valid` low and a zero on `in_data` are mixed into the stream, so any dependence on bytes that did not transfer is caught.

// File: rtl/cobs_sig_pkg.sv
package cobs_sig_pkg;

  localparam int FLAG_W = 32;

  localparam logic [FLAG_W-1:0] SIG_NULL    = 32'h0000_0001;
  localparam logic [FLAG_W-1:0] SIG_WR_OK   = 32'h0000_0002;
  localparam logic [FLAG_W-1:0] SIG_WR_FAIL = 32'h0000_0004;
  localparam logic [FLAG_W-1:0] SIG_RD_OK   = 32'h0000_0008;
  localparam logic [FLAG_W-1:0] SIG_RD_FAIL = 32'h0000_0010;
  localparam logic [FLAG_W-1:0] SIG_TAB     = 32'h0000_0020;
  localparam logic [FLAG_W-1:0] SIG_DEV     = 32'h0000_0040;

  typedef enum logic [2:0] {
    PK_NONE,
    PK_WR_OK,
    PK_WR_FAIL,
    PK_RD_OK,
    PK_RD_FAIL,
    PK_TAB,
    PK_DEV,
    PK_ERR
  } pkt_kind_e;

endpackage

// File: rtl/cobs_sig_unstuff.sv
// Removes byte stuffing one transferred byte at a time; at most one decoded
// byte leaves per input byte, combinationally.
module cobs_sig_unstuff (
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic [7:0] byte_i,
  output logic       dv_o,
  output logic [7:0] db_o,
  output logic       end_o,
  output logic       end_bad_o,
  output logic       end_empty_o
);

  logic [7:0] left_q;   // literal bytes still owed by the current group
  logic       open_q;   // a code byte has been seen in this packet
  logic       long_q;   // current group was a full 0xFF group (no implied zero)

  always_comb begin
    dv_o        = 1'b0;
    db_o        = 8'h00;
    end_o       = 1'b0;
    end_bad_o   = 1'b0;
    end_empty_o = 1'b0;
    if (fire) begin
      if (byte_i == 8'h00) begin
        end_o       = 1'b1;
        end_bad_o   = (left_q != 8'h00);
        end_empty_o = !open_q;
      end else if (left_q == 8'h00) begin
        // new group: close the previous one with its implied zero
        dv_o = open_q && !long_q;
        db_o = 8'h00;
      end else begin
        dv_o = 1'b1;
        db_o = byte_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= 8'h00;
      open_q <= 1'b0;
      long_q <= 1'b0;
    end else if (fire) begin
      if (byte_i == 8'h00) begin
        left_q <= 8'h00;
        open_q <= 1'b0;
        long_q <= 1'b0;
      end else if (left_q == 8'h00) begin
        left_q <= byte_i - 8'd1;
        open_q <= 1'b1;
        long_q <= (byte_i == 8'hFF);
      end else begin
        left_q <= left_q - 8'd1;
      end
    end
  end

endmodule

// File: rtl/cobs_sig_parse.sv
// Assembles flag, first payload word and descriptor words from decoded bytes,
// and classifies the packet when its delimiter arrives.
module cobs_sig_parse
  import cobs_sig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dv_i,
  input  logic [7:0]       db_i,
  input  logic             end_i,
  input  logic             end_bad_i,
  input  logic             end_empty_i,
  output pkt_kind_e        kind_o,
  output logic [31:0]      word_o,
  output logic [CNT_W-3:0] nwords_o,
  output logic             desc_v_o,
  output logic [31:0]      desc_word_o,
  output logic [CNT_W-3:0] desc_idx_o
);

  localparam logic [CNT_W-1:0] LEN_FLAG = CNT_W'(4);
  localparam logic [CNT_W-1:0] LEN_WORD = CNT_W'(8);

  logic [CNT_W-1:0]  cnt_q;
  logic [FLAG_W-1:0] flag_q;
  logic [31:0]       first_q;
  logic [23:0]       part_q;
  logic              sat_c;
  logic [CNT_W-1:0]  off_c;
  pkt_kind_e         kind_c;

  assign sat_c = &cnt_q;
  assign off_c = cnt_q - LEN_WORD;

  always_comb begin
    kind_c = PK_ERR;
    if (!end_bad_i && !sat_c && cnt_q >= LEN_FLAG) begin
      case (flag_q)
        SIG_NULL:    kind_c = PK_NONE;
        SIG_WR_OK:   kind_c = (cnt_q == LEN_FLAG) ? PK_WR_OK   : PK_ERR;
        SIG_WR_FAIL: kind_c = (cnt_q == LEN_FLAG) ? PK_WR_FAIL : PK_ERR;
        SIG_RD_FAIL: kind_c = (cnt_q == LEN_FLAG) ? PK_RD_FAIL : PK_ERR;
        SIG_RD_OK:   kind_c = (cnt_q == LEN_WORD) ? PK_RD_OK   : PK_ERR;
        SIG_TAB:     kind_c = (cnt_q == LEN_WORD) ? PK_TAB     : PK_ERR;
        SIG_DEV:     kind_c = (cnt_q >= LEN_WORD && cnt_q[1:0] == 2'd0) ? PK_DEV : PK_ERR;
        default:     kind_c = PK_ERR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      flag_q      <= '0;
      first_q     <= '0;
      part_q      <= '0;
      kind_o      <= PK_NONE;
      word_o      <= '0;
      nwords_o    <= '0;
      desc_v_o    <= 1'b0;
      desc_word_o <= '0;
      desc_idx_o  <= '0;
    end else begin
      kind_o   <= PK_NONE;
      desc_v_o <= 1'b0;
      if (end_i) begin
        kind_o   <= end_empty_i ? PK_NONE : kind_c;
        word_o   <= first_q;
        nwords_o <= off_c[CNT_W-1:2];
        cnt_q    <= '0;
      end else if (dv_i) begin
        if (!sat_c) cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q < LEN_FLAG) begin
          flag_q[8*cnt_q[1:0] +: 8] <= db_i;
        end else if (cnt_q < LEN_WORD) begin
          first_q[8*cnt_q[1:0] +: 8] <= db_i;
        end else if (cnt_q[1:0] == 2'd3) begin
          if (flag_q == SIG_DEV) begin
            desc_v_o    <= 1'b1;
            desc_word_o <= {db_i, part_q};
            desc_idx_o  <= off_c[CNT_W-1:2];
          end
        end else begin
          part_q[8*cnt_q[1:0] +: 8] <= db_i;
        end
      end
    end
  end

endmodule

// File: rtl/cobs_sig_devtab.sv
// Counts device packets against the announced table size.
module cobs_sig_devtab (
  input  logic        clk,
  input  logic        rst,
  input  logic        tab_v_i,
  input  logic [31:0] tab_n_i,
  input  logic        dev_v_i,
  output logic        done_o
);

  logic        open_q;
  logic [31:0] left_q;

  assign done_o = (tab_v_i && tab_n_i == 32'd0) ||
                  (dev_v_i && open_q && left_q == 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      left_q <= '0;
    end else if (tab_v_i) begin
      open_q <= (tab_n_i != 32'd0);
      left_q <= tab_n_i;
    end else if (dev_v_i && open_q) begin
      left_q <= left_q - 32'd1;
      if (left_q == 32'd1) open_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cobs_sig_rx.sv
module cobs_sig_rx
  import cobs_sig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             ack_wr_ok,
  output logic             ack_wr_fail,
  output logic             ack_rd_ok,
  output logic             ack_rd_fail,
  output logic [31:0]      rd_value,
  output logic             tab_valid,
  output logic [31:0]      tab_count,
  output logic             desc_valid,
  output logic [31:0]      desc_word,
  output logic [CNT_W-3:0] desc_index,
  output logic             dev_valid,
  output logic [31:0]      dev_addr,
  output logic [CNT_W-3:0] dev_words,
  output logic             tab_done,
  output logic             pkt_err
);

  logic        fire;
  logic        dv, dend, dbad, dempty;
  logic [7:0]  db;
  pkt_kind_e   kind;
  logic [31:0] word;

  assign in_ready = !rst;
  assign fire     = in_valid && in_ready;

  cobs_sig_unstuff unstuff_i (
    .clk(clk), .rst(rst), .fire(fire), .byte_i(in_data),
    .dv_o(dv), .db_o(db), .end_o(dend), .end_bad_o(dbad), .end_empty_o(dempty)
  );

  cobs_sig_parse #(.CNT_W(CNT_W)) parse_i (
    .clk(clk), .rst(rst), .dv_i(dv), .db_i(db), .end_i(dend),
    .end_bad_i(dbad), .end_empty_i(dempty),
    .kind_o(kind), .word_o(word), .nwords_o(dev_words),
    .desc_v_o(desc_valid), .desc_word_o(desc_word), .desc_idx_o(desc_index)
  );

  assign ack_wr_ok   = (kind == PK_WR_OK);
  assign ack_wr_fail = (kind == PK_WR_FAIL);
  assign ack_rd_ok   = (kind == PK_RD_OK);
  assign ack_rd_fail = (kind == PK_RD_FAIL);
  assign tab_valid   = (kind == PK_TAB);
  assign dev_valid   = (kind == PK_DEV);
  assign pkt_err     = (kind == PK_ERR);
  assign rd_value    = word;
  assign tab_count   = word;
  assign dev_addr    = word;

  cobs_sig_devtab devtab_i (
    .clk(clk), .rst(rst), .tab_v_i(tab_valid), .tab_n_i(tab_count),
    .dev_v_i(dev_valid), .done_o(tab_done)
  );

endmodule

// File: rtl/cobs_sig_rx_chk.sv
module cobs_sig_rx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       in_data,
  input logic             in_valid,
  input logic             in_ready,
  input logic             ack_wr_ok,
  input logic             ack_wr_fail,
  input logic             ack_rd_ok,
  input logic             ack_rd_fail,
  input logic             tab_valid,
  input logic             desc_valid,
  input logic             dev_valid,
  input logic             tab_done,
  input logic             pkt_err
);

  logic any_res;
  assign any_res = ack_wr_ok | ack_wr_fail | ack_rd_ok | ack_rd_fail |
                   tab_valid | dev_valid | pkt_err;

  // R9: one classification per packet
  a_r9_one_result: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_wr_ok, ack_wr_fail, ack_rd_ok, ack_rd_fail, tab_valid, dev_valid, pkt_err}));

  // R11: packet results follow a transferred delimiter
  a_r11_result_after_zero: assert property (@(posedge clk) disable iff (rst)
    any_res |-> $past(in_valid && in_ready && in_data == 8'h00));

  // R8: descriptor words follow a transferred non-zero byte
  a_r8_desc_after_byte: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> $past(in_valid && in_ready && in_data != 8'h00));

  // R10: done only rides on a header or device result
  a_r10_done_with_event: assert property (@(posedge clk) disable iff (rst)
    tab_done |-> (tab_valid || dev_valid));

  // R12: quiet in the first cycle after reset
  a_r12_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(any_res || desc_valid || tab_done));

  // R11: ready whenever out of reset
  a_r11_ready: assert property (@(posedge clk) disable iff (rst) in_ready);

endmodule

bind cobs_sig_rx cobs_sig_rx_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
  .ack_wr_ok(ack_wr_ok), .ack_wr_fail(ack_wr_fail), .ack_rd_ok(ack_rd_ok),
  .ack_rd_fail(ack_rd_fail), .tab_valid(tab_valid), .desc_valid(desc_valid),
  .dev_valid(dev_valid), .tab_done(tab_done), .pkt_err(pkt_err)
);

// File: tb/cobs_sig_rx_tb_top.sv
`timescale 1ns/1ps
module cobs_sig_rx_tb_top;

  localparam int CNT_W = 16;
  typedef logic [7:0] bq_t [$];

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       in_data = 8'h00;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             ack_wr_ok, ack_wr_fail, ack_rd_ok, ack_rd_fail;
  logic [31:0]      rd_value, tab_count, desc_word, dev_addr;
  logic             tab_valid, desc_valid, dev_valid, tab_done, pkt_err;
  logic [CNT_W-3:0] desc_index, dev_words;

  always #4 clk = ~clk;

  cobs_sig_rx #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .ack_wr_ok(ack_wr_ok), .ack_wr_fail(ack_wr_fail), .ack_rd_ok(ack_rd_ok),
    .ack_rd_fail(ack_rd_fail), .rd_value(rd_value), .tab_valid(tab_valid),
    .tab_count(tab_count), .desc_valid(desc_valid), .desc_word(desc_word),
    .desc_index(desc_index), .dev_valid(dev_valid), .dev_addr(dev_addr),
    .dev_words(dev_words), .tab_done(tab_done), .pkt_err(pkt_err)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string ctx = "R12 reset";
  int    gapc = 0;

  // expectations for the coming cycle
  bit          e_wok, e_wfail, e_rok, e_rfail, e_tab, e_desc, e_dev, e_done, e_err;
  logic [31:0] e_rd, e_cnt, e_dw, e_addr;
  int          e_di, e_nw;

  // model state
  bq_t raw;
  int  dlen = 0;
  bit  m_open = 0;
  longint m_left = 0;
  bq_t cur;

  function automatic void dec(input bq_t r, output bq_t d, output bit short);
    int  i = 0;
    bit  first = 1;
    logic [7:0] prev = 8'h00;
    d = {};
    short = 0;
    while (i < r.size()) begin
      logic [7:0] c = r[i];
      if (!first && prev != 8'hFF) d.push_back(8'h00);
      first = 0;
      prev = c;
      i++;
      for (int k = 1; k < c; k++) begin
        if (i < r.size()) begin d.push_back(r[i]); i++; end
        else begin short = 1; break; end
      end
    end
  endfunction

  function automatic void enc(input bq_t d, output bq_t e);
    bq_t blk = {};
    e = {};
    foreach (d[i]) begin
      if (d[i] == 8'h00) begin
        e.push_back(8'(blk.size() + 1));
        foreach (blk[j]) e.push_back(blk[j]);
        blk = {};
      end else begin
        blk.push_back(d[i]);
        if (blk.size() == 254) begin
          e.push_back(8'hFF);
          foreach (blk[j]) e.push_back(blk[j]);
          blk = {};
        end
      end
    end
    e.push_back(8'(blk.size() + 1));
    foreach (blk[j]) e.push_back(blk[j]);
  endfunction

  function automatic logic [31:0] w32(bq_t d, int at);
    return {d[at+3], d[at+2], d[at+1], d[at]};
  endfunction

  task automatic classify();
    bq_t d;
    bit  sh;
    int  n;
    logic [31:0] f;
    dec(raw, d, sh);
    n = d.size();
    if (sh || n < 4) begin e_err = 1; return; end
    f = w32(d, 0);
    case (f)
      32'h1:  ;
      32'h2:  if (n == 4) e_wok = 1;   else e_err = 1;
      32'h4:  if (n == 4) e_wfail = 1; else e_err = 1;
      32'h10: if (n == 4) e_rfail = 1; else e_err = 1;
      32'h8:  if (n == 8) begin e_rok = 1; e_rd = w32(d, 4); end else e_err = 1;
      32'h20: if (n == 8) begin
                e_tab = 1; e_cnt = w32(d, 4);
                if (e_cnt == 0) begin e_done = 1; m_open = 0; end
                else begin m_open = 1; m_left = e_cnt; end
              end else e_err = 1;
      32'h40: if (n >= 8 && n % 4 == 0) begin
                e_dev = 1; e_addr = w32(d, 4); e_nw = (n - 8) / 4;
                if (m_open) begin
                  if (m_left == 1) begin e_done = 1; m_open = 0; end
                  m_left--;
                end
              end else e_err = 1;
      default: e_err = 1;
    endcase
  endtask

  task automatic model_byte(input logic [7:0] b);
    bq_t d;
    bit  sh;
    if (b == 8'h00) begin
      if (raw.size() > 0) classify();
      raw = {};
      dlen = 0;
    end else begin
      raw.push_back(b);
      dec(raw, d, sh);
      if (d.size() > dlen) begin
        int i;
        dlen = d.size();
        i = dlen - 1;
        if (i >= 8 && i % 4 == 3 && w32(d, 0) == 32'h40) begin
          e_desc = 1; e_dw = w32(d, i - 3); e_di = (i - 8) / 4;
        end
      end
    end
  endtask

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL [%s] %s actual=%h expected=%h", ctx, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(in_ready === !rst, "R11 in_ready", 32'(in_ready), 32'(!rst));
    if (rst) chk({ack_wr_ok, ack_wr_fail, ack_rd_ok, ack_rd_fail, tab_valid, desc_valid,
                  dev_valid, tab_done, pkt_err} === '0, "R12 strobes in reset", 0, 0);
    chk(ack_wr_ok === e_wok, "R5 ack_wr_ok", 32'(ack_wr_ok), 32'(e_wok));
    chk(ack_wr_fail === e_wfail, "R5 ack_wr_fail", 32'(ack_wr_fail), 32'(e_wfail));
    chk(ack_rd_fail === e_rfail, "R5 ack_rd_fail", 32'(ack_rd_fail), 32'(e_rfail));
    chk(ack_rd_ok === e_rok, "R6 ack_rd_ok", 32'(ack_rd_ok), 32'(e_rok));
    if (e_rok) chk(rd_value === e_rd, "R6 rd_value", rd_value, e_rd);
    chk(tab_valid === e_tab, "R7 tab_valid", 32'(tab_valid), 32'(e_tab));
    if (e_tab) chk(tab_count === e_cnt, "R7 tab_count", tab_count, e_cnt);
    chk(desc_valid === e_desc, "R8 desc_valid", 32'(desc_valid), 32'(e_desc));
    if (e_desc) begin
      chk(desc_word === e_dw, "R8 desc_word", desc_word, e_dw);
      chk(32'(desc_index) === 32'(e_di), "R8 desc_index", 32'(desc_index), 32'(e_di));
    end
    chk(dev_valid === e_dev, "R8 dev_valid", 32'(dev_valid), 32'(e_dev));
    if (e_dev) begin
      chk(dev_addr === e_addr, "R8 dev_addr", dev_addr, e_addr);
      chk(32'(dev_words) === 32'(e_nw), "R8 dev_words", 32'(dev_words), 32'(e_nw));
    end
    chk(tab_done === e_done, "R10 tab_done", 32'(tab_done), 32'(e_done));
    chk(pkt_err === e_err, "R9 pkt_err", 32'(pkt_err), 32'(e_err));
  endtask

  task automatic cyc(input bit v, input logic [7:0] b);
    @(negedge clk);
    compare();
    {e_wok, e_wfail, e_rok, e_rfail, e_tab, e_desc, e_dev, e_done, e_err} = '0;
    if (v && !rst) model_byte(b);
    in_valid = v;
    in_data  = b;
  endtask

  task automatic send_raw(input bq_t r);
    foreach (r[i]) begin
      cyc(1'b1, r[i]);
      gapc++;
      if (gapc % 5 == 4) cyc(1'b0, 8'h00);   // R11: idle zero must not count
    end
  endtask

  task automatic send(input bq_t d);
    bq_t e;
    enc(d, e);
    e.push_back(8'h00);
    send_raw(e);
  endtask

  task automatic start(input logic [31:0] f);
    cur = {};
    for (int i = 0; i < 4; i++) cur.push_back(f[8*i +: 8]);
  endtask

  task automatic add(input logic [31:0] w);
    for (int i = 0; i < 4; i++) cur.push_back(w[8*i +: 8]);
  endtask

  initial begin
    repeat (3) cyc(1'b0, 8'h00);
    rst = 1'b0;
    ctx = "R12 after reset";
    repeat (2) cyc(1'b0, 8'h00);

    ctx = "R4 null dropped";
    start(32'h1); add(32'hDEAD0001); send(cur);
    start(32'h1); send(cur);

    ctx = "R5 write ack";       start(32'h2);  send(cur);
    ctx = "R5 write refused";   start(32'h4);  send(cur);
    ctx = "R5 read refused";    start(32'h10); send(cur);
    ctx = "R6 read ack zeros";  start(32'h8);  add(32'h00A1B200); send(cur);
    ctx = "R6 read ack";        start(32'h8);  add(32'h7F3C2B19); send(cur);
    ctx = "R5 payload on write ack"; start(32'h2); add(32'h5); send(cur);
    ctx = "R6 short read";      start(32'h8);  cur.push_back(8'h11); send(cur);
    ctx = "R3 two bits set";    start(32'h3);  send(cur);
    ctx = "R3 unknown bit";     start(32'h80); send(cur);
    ctx = "R3 zero flag";       start(32'h0);  send(cur);

    ctx = "R7 header";          start(32'h20); add(32'd2); send(cur);
    ctx = "R8 device three words";
    start(32'h40); add(32'h0001_0200); add(32'hA0B0C0D0); add(32'h0000_0000); add(32'h1234_5600);
    send(cur);
    ctx = "R10 second device";  start(32'h40); add(32'h0002_0000); send(cur);
    ctx = "R10 device after done"; start(32'h40); add(32'h3); send(cur);
    ctx = "R10 empty table";    start(32'h20); add(32'd0); send(cur);

    ctx = "R8 bad device length"; start(32'h40); add(32'h9); cur.push_back(8'h01); send(cur);
    ctx = "R9 device no address"; start(32'h40); send(cur);

    ctx = "R9 code runs past delimiter";
    send_raw('{8'h05, 8'h08, 8'h11, 8'h00});
    ctx = "R1 resync after bad"; start(32'h2); send(cur);
    ctx = "R9 under four bytes";  send_raw('{8'h03, 8'h02, 8'h01, 8'h00});
    ctx = "R1 empty packets";     send_raw('{8'h00, 8'h00, 8'h00});
    ctx = "R1 join mid stream";   send_raw('{8'h07, 8'h55, 8'h66, 8'h00});

    ctx = "R2 long run";
    start(32'h20); add(32'd1); send(cur);
    start(32'h40); add(32'h11223344);
    for (int k = 0; k < 64; k++) add({4{8'(k + 1)}});
    send(cur);
    ctx = "R2 long run then zero";
    start(32'h40); add(32'h01010101);
    for (int k = 0; k < 62; k++) add(32'h02020202);
    add(32'h00000000);
    send(cur);

    repeat (3) cyc(1'b0, 8'h00);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL [watchdog] run did not end actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule